// File: doc/BRIEF.md
# Multi-channel IO freeze sequencer

This block drives the pad control lines of a set of identical general-purpose IO channels into and out of a frozen state. Software pulses a freeze request or a thaw request and supplies a channel mask. The block then walks each selected channel, one at a time in ascending channel order, through a fixed series of writes to its pad control lines. A minimum settling gap separates consecutive writes. Thawing runs the lines back in the opposite order to freezing.

Each channel has five control lines: slew enable, weak pull-up enable, tristate enable, bus-hold enable and configuration-done. Every line is active low. A 0 asserts the pad function and a 1 releases it. Each channel also has a frozen/thawed status flag.

When a request is accepted, the block first switches the freeze source from the hardware default to software control. A busy flag covers the whole run. Requests that arrive while the block is busy are dropped.

Top module: `io_freeze_seq`

## Requirements
- R1: After reset, every control line of every channel is 0, every frozen flag is 1, busy is 0, and the source select is 0, meaning the hardware default.
- R2: The source select goes to 1, meaning software, in the cycle after the first accepted request. From then until the next reset it never returns to 0.
- R3: A freeze on a channel clears slew, pull-up and tristate in one write. Exactly GAP_CYC cycles later, a second write clears bus-hold and configuration-done.
- R4: A thaw on a channel sets bus-hold and configuration-done in one write. GAP_CYC cycles later it sets pull-up and tristate. A further GAP_CYC cycles later it sets slew.
- R5: A channel's frozen flag changes in the same cycle as the last write of its sequence. It becomes 1 after a freeze and 0 after a thaw.
- R6: The channels set in ch_mask_i are handled one at a time, in ascending index order. Each channel's sequence begins on the cycle after the previous channel's sequence ends.
- R7: busy_o rises in the cycle after a request is accepted. It stays high until every selected channel has been handled. A request is accepted only while busy_o is low; requests seen while it is high have no effect.
- R8: A freeze aimed at a channel that is already frozen, or a thaw aimed at a channel that is already thawed, uses a single cycle and leaves that channel's lines and flag unchanged.
- R9: If a freeze request and a thaw request are asserted in the same cycle, the freeze is carried out.
- R10: Channels whose bit is clear in the accepted mask keep their lines and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freeze_req_i | input | 1 | Freeze request pulse |
| thaw_req_i | input | 1 | Thaw request pulse |
| ch_mask_i | input | N_CH | Channels that the request applies to |
| src_sw_o | output | 1 | 1 when software is selected as the freeze source |
| busy_o | output | 1 | High while a request is being carried out |
| slew_o | output | N_CH | Slew enable per channel, active low |
| pullup_o | output | N_CH | Weak pull-up enable per channel, active low |
| tristate_o | output | N_CH | Tristate enable per channel, active low |
| bushold_o | output | N_CH | Bus-hold enable per channel, active low |
| cfgdone_o | output | N_CH | Configuration-done per channel, active low |
| frozen_o | output | N_CH | Status per channel, 1 means frozen |

## Verification
The bench builds the block with N_CH = 3 and GAP_CYC = 3. With a gap of three cycles, a write that lands one cycle early or one cycle late cannot be mistaken for a correct write. It also shows whether the gap timer is reloaded between steps or keeps running from the previous step.

Three channels are enough to run a mask in which a redundant channel sits between two channels that need work. They also allow a single-channel mask that leaves both neighbours untouched.

// File: rtl/io_frz_pkg.sv
package io_frz_pkg;
  typedef enum logic {OP_FREEZE = 1'b0, OP_THAW = 1'b1} op_e;
  localparam int unsigned STEP_W = 2;
  function automatic logic [STEP_W-1:0] last_step(op_e op);
    return (op == OP_THAW) ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/io_frz_gap.sv
module io_frz_gap #(
  parameter int unsigned GAP_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(GAP_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CNT_W'(GAP_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/io_frz_chan.sv
module io_frz_chan
  import io_frz_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  op_e               op_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              slew_o,
  output logic              pullup_o,
  output logic              tristate_o,
  output logic              bushold_o,
  output logic              cfgdone_o,
  output logic              frozen_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {slew_o, pullup_o, tristate_o, bushold_o, cfgdone_o} <= '0;
      frozen_o <= 1'b1;
    end else if (wr_i) begin
      if (op_i == OP_FREEZE) begin
        case (step_i)
          2'd0: {slew_o, pullup_o, tristate_o} <= '0;
          2'd1: begin {bushold_o, cfgdone_o} <= '0; frozen_o <= 1'b1; end
          default: ;
        endcase
      end else begin
        case (step_i)
          2'd0: {bushold_o, cfgdone_o} <= 2'b11;
          2'd1: {pullup_o, tristate_o} <= 2'b11;
          2'd2: begin slew_o <= 1'b1; frozen_o <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  // R3
  bushold_after_slew_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bushold_o) |-> !slew_o && !tristate_o);
  // R4
  slew_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slew_o) |-> $past(pullup_o) && $past(bushold_o));
  // R5
  frozen_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frozen_o) |-> !cfgdone_o && !slew_o);
  // R5
  thawed_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frozen_o) |-> slew_o && pullup_o && bushold_o);
endmodule

// File: rtl/io_frz_seq.sv
module io_frz_seq
  import io_frz_pkg::*;
#(
  parameter int unsigned N_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              freeze_req_i,
  input  logic              thaw_req_i,
  input  logic [N_CH-1:0]   ch_mask_i,
  input  logic [N_CH-1:0]   frozen_i,
  input  logic              expired_i,
  output logic              load_o,
  output logic [N_CH-1:0]   wr_o,
  output op_e               op_o,
  output logic [STEP_W-1:0] step_o,
  output logic              busy_o,
  output logic              src_sw_o
);
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  typedef enum logic [1:0] {S_IDLE, S_SEL, S_WAIT} state_e;

  state_e            state_q;
  op_e               op_q;
  logic [N_CH-1:0]   pend_q;
  logic [CH_W-1:0]   ch_q, pick;
  logic [STEP_W-1:0] step_q;
  logic              found, redundant, is_last, start;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (pend_q[i]) begin found = 1'b1; pick = CH_W'(i); end
    end
  end

  assign redundant = (op_q == OP_FREEZE) ? frozen_i[pick] : !frozen_i[pick];
  assign is_last   = (step_q == last_step(op_q));
  assign start     = (state_q == S_SEL) && found && !redundant;

  always_comb begin
    wr_o   = '0;
    step_o = '0;
    if (start) begin
      wr_o[pick] = 1'b1;
    end else if (state_q == S_WAIT && expired_i) begin
      wr_o[ch_q] = 1'b1;
      step_o     = step_q;
    end
  end

  assign load_o = start || (state_q == S_WAIT && expired_i && !is_last);
  assign op_o   = op_q;
  assign busy_o = (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      op_q     <= OP_FREEZE;
      pend_q   <= '0;
      ch_q     <= '0;
      step_q   <= '0;
      src_sw_o <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (freeze_req_i || thaw_req_i) begin
          op_q     <= freeze_req_i ? OP_FREEZE : OP_THAW;
          pend_q   <= ch_mask_i;
          src_sw_o <= 1'b1;
          state_q  <= S_SEL;
        end
        S_SEL: begin
          if (!found)        state_q <= S_IDLE;
          else if (redundant) pend_q[pick] <= 1'b0;
          else begin
            ch_q    <= pick;
            step_q  <= STEP_W'(1);
            state_q <= S_WAIT;
          end
        end
        S_WAIT: if (expired_i) begin
          if (is_last) begin
            pend_q[ch_q] <= 1'b0;
            state_q      <= S_SEL;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2
  src_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(src_sw_o));
  // R6
  one_writer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_o));
  // R7
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (freeze_req_i || thaw_req_i)) |=> busy_o && src_sw_o);
  // R7
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != S_IDLE) |=> $stable(op_q));
endmodule

// File: rtl/io_freeze_seq.sv
module io_freeze_seq
  import io_frz_pkg::*;
#(
  parameter int unsigned N_CH    = 3,
  parameter int unsigned GAP_CYC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            freeze_req_i,
  input  logic            thaw_req_i,
  input  logic [N_CH-1:0] ch_mask_i,
  output logic            src_sw_o,
  output logic            busy_o,
  output logic [N_CH-1:0] slew_o,
  output logic [N_CH-1:0] pullup_o,
  output logic [N_CH-1:0] tristate_o,
  output logic [N_CH-1:0] bushold_o,
  output logic [N_CH-1:0] cfgdone_o,
  output logic [N_CH-1:0] frozen_o
);
  logic              load, expired;
  logic [N_CH-1:0]   wr;
  op_e               op;
  logic [STEP_W-1:0] step;

  io_frz_gap #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i, .rst_ni, .load_i(load), .expired_o(expired)
  );

  io_frz_seq #(.N_CH(N_CH)) u_seq (
    .clk_i, .rst_ni, .freeze_req_i, .thaw_req_i, .ch_mask_i,
    .frozen_i(frozen_o), .expired_i(expired), .load_o(load),
    .wr_o(wr), .op_o(op), .step_o(step), .busy_o, .src_sw_o
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    io_frz_chan u_chan (
      .clk_i, .rst_ni, .wr_i(wr[c]), .op_i(op), .step_i(step),
      .slew_o(slew_o[c]), .pullup_o(pullup_o[c]), .tristate_o(tristate_o[c]),
      .bushold_o(bushold_o[c]), .cfgdone_o(cfgdone_o[c]), .frozen_o(frozen_o[c])
    );
  end
endmodule

// File: tb/io_freeze_seq_tb.sv
module io_freeze_seq_tb;
  localparam int N = 3;
  localparam int GAP = 3;

  logic clk = 1'b0, rst_n = 1'b0, frz = 1'b0, thw = 1'b0;
  logic [N-1:0] mask = '0;
  logic src, busy;
  logic [N-1:0] sl, pu, ts, bh, cd, fz;

  io_freeze_seq #(.N_CH(N), .GAP_CYC(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .freeze_req_i(frz), .thaw_req_i(thw),
    .ch_mask_i(mask), .src_sw_o(src), .busy_o(busy), .slew_o(sl),
    .pullup_o(pu), .tristate_o(ts), .bushold_o(bh), .cfgdone_o(cd), .frozen_o(fz)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, ecnt = 0, cyc = 0;
  typedef struct {int edge_n; int ch; int code;} ev_t;
  ev_t evq[$];
  bit m_sl[N], m_pu[N], m_ts[N], m_bh[N], m_cd[N], m_fz[N];
  bit m_busy, m_src;

  task automatic model_reset();
    for (int c = 0; c < N; c++) begin
      m_sl[c] = 0; m_pu[c] = 0; m_ts[c] = 0; m_bh[c] = 0; m_cd[c] = 0; m_fz[c] = 1;
    end
    m_busy = 0; m_src = 0; evq.delete();
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      ecnt++;
      if (!m_busy && (frz || thw)) begin
        int op, cur;
        op = frz ? 0 : 1;   // R9 freeze wins
        m_busy = 1; m_src = 1;
        cur = ecnt + 1;
        for (int c = 0; c < N; c++) if (mask[c]) begin
          bit red;
          red = (op == 0) ? m_fz[c] : !m_fz[c];
          if (red) cur += 1;   // R8
          else begin
            int nst;
            nst = op ? 3 : 2;
            for (int k = 0; k < nst; k++) evq.push_back('{cur + k*GAP, c, op*4 + k});
            cur = cur + (nst-1)*GAP + 1;
          end
        end
        evq.push_back('{cur, 0, 99});
      end
      for (int i = evq.size() - 1; i >= 0; i--) if (evq[i].edge_n == ecnt) begin
        int c;
        c = evq[i].ch;
        case (evq[i].code)
          0: begin m_sl[c] = 0; m_pu[c] = 0; m_ts[c] = 0; end
          1: begin m_bh[c] = 0; m_cd[c] = 0; m_fz[c] = 1; end
          4: begin m_bh[c] = 1; m_cd[c] = 1; end
          5: begin m_pu[c] = 1; m_ts[c] = 1; end
          6: begin m_sl[c] = 1; m_fz[c] = 0; end
          default: m_busy = 0;
        endcase
        evq.delete(i);
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk(busy == m_busy, "R7", "busy", busy, m_busy);
    chk(src == m_src, "R2", "src_sw", src, m_src);
    for (int c = 0; c < N; c++) begin
      chk(sl[c] == m_sl[c], "R3/R4", $sformatf("slew[%0d]", c), sl[c], m_sl[c]);
      chk(pu[c] == m_pu[c], "R3/R4", $sformatf("pullup[%0d]", c), pu[c], m_pu[c]);
      chk(ts[c] == m_ts[c], "R3/R4", $sformatf("tristate[%0d]", c), ts[c], m_ts[c]);
      chk(bh[c] == m_bh[c], "R3/R4", $sformatf("bushold[%0d]", c), bh[c], m_bh[c]);
      chk(cd[c] == m_cd[c], "R3/R4", $sformatf("cfgdone[%0d]", c), cd[c], m_cd[c]);
      chk(fz[c] == m_fz[c], "R5", $sformatf("frozen[%0d]", c), fz[c], m_fz[c]);
    end
  end

  task automatic request(bit f, bit t, logic [N-1:0] m);
    @(negedge clk); frz = f; thw = t; mask = m;
    @(negedge clk); frz = 0; thw = 0; mask = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sl == '0 && cd == '0 && fz == '1 && !busy && !src, "R1", "reset state", int'(fz), 7);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    request(0, 1, 3'b111);        // R4 R6 thaw all in order
    wait_idle();
    request(1, 0, 3'b010);        // R3 R10 freeze middle only
    wait_idle();
    chk(fz == 3'b010, "R10", "frozen map", int'(fz), 2);
    request(0, 1, 3'b111);        // R8 redundant neighbours around a real thaw
    wait_idle();
    request(1, 0, 3'b101);        // R7 request while busy is dropped
    repeat (4) @(negedge clk);
    frz = 0; thw = 1; mask = 3'b010;
    @(negedge clk); thw = 0; mask = '0;
    wait_idle();
    chk(fz == 3'b101, "R7", "frozen map after ignored thaw", int'(fz), 5);
    request(1, 1, 3'b010);        // R9 both requests, freeze wins
    wait_idle();
    chk(fz == 3'b111, "R9", "frozen map", int'(fz), 7);
    request(1, 0, 3'b111);        // R8 all redundant
    wait_idle();
    request(0, 1, 3'b000);        // empty mask
    wait_idle();
    request(0, 1, 3'b100);        // R10 single channel at top index
    wait_idle();
    chk(fz == 3'b011, "R10", "frozen map", int'(fz), 3);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule